// File: doc/BRIEF.md
# Prioritized UART interrupt identification

This block holds the interrupt side of a 16550-style serial register model. It stores the interrupt-enable nibble, the FIFO-mode flag, the scratch byte and the baud divisor. It tracks a latched transmitter-empty pending flag and an overrun flag. From these and from the receive and modem inputs it picks the most urgent enabled cause. That cause is reported through the identification register and through a level interrupt line.

A host bus issues single-cycle read or write strobes with a 3-bit offset. The divisor-access bit comes from the line-control logic next to this block. The receive buffer is outside the block. It reports whether it is non-empty and what its head byte is, and it takes a pop pulse when the data offset is read. Serial shifting is not modelled, so the transmitter always reads as ready. Read data appears one clock after the read strobe. The interrupt line is registered and reflects the state reached after each edge.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the interrupt line is low, the enable register reads 0x00, the identification register reads 0x01 and the divisor reads 12 (low byte) and 0 (high byte).
- R2: A write to offset 1 with the divisor-access bit clear stores only bits 3:0 (bit0 receive, bit1 transmit-empty, bit2 line status, bit3 modem). Bits 7:4 read back as zero.
- R3: Identification bits 3:0 report the highest-priority enabled cause. In order from high to low: overrun 0x6, receive data 0xC, transmit-empty pending 0x2, modem delta 0x0. With no enabled cause they read 0x1.
- R4: Whenever the receive buffer is non-empty and bit0 is enabled, and no overrun is enabled, the reported code is 0xC.
- R5: A write to the data offset (divisor-access clear) sets the transmit-empty pending flag. A read of offset 2 that reports 0x2 clears it.
- R6: A write to offset 1 sets the pending flag only when bit1 goes from 0 to 1. Rewriting bit1 as 1 while it is already 1 leaves the flag unchanged.
- R7: A read of offset 2 that reports any other cause leaves the pending flag set.
- R8: Writing offset 2 with bit0 set enables FIFO mode, and bits 7:6 of the identification register then read as 11. Writing bit0 clear makes them read 00.
- R9: A read of offset 5 returns bit6 and bit5 set, bit0 set when the receive buffer is non-empty, and bit1 set when an overrun is held. The overrun is cleared after that read unless a new overrun event arrives in the same cycle.
- R10: With the divisor-access bit set, offsets 0 and 1 read and write the divisor low and high bytes.
- R11: The interrupt line is high, one clock after the state or the inputs change, exactly when some cause is enabled and present.
- R12: Writes to offsets 5 and 6 have no effect. Offset 7 reads back the last byte written. Offsets 3, 4 and 6 read as 0x00.
- R13: A read of offset 0 with the divisor-access bit clear returns the receive head byte and pulses the pop output for that cycle. Divisor reads do not pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| dlab | input | 1 | Divisor-access select from line control |
| rx_nonempty | input | 1 | Receive buffer holds at least one byte |
| rx_head | input | 8 | Byte at the head of the receive buffer |
| ovr_evt | input | 1 | One-cycle overrun event |
| msr_delta | input | 1 | Any modem-status delta bit is set |
| rdata | output | 8 | Read data, valid the cycle after rd_en |
| rx_pop | output | 1 | Pop request to the receive buffer |
| irq | output | 1 | Level interrupt request |

## Verification
All four causes are raised together and then withdrawn one at a time. Each identification read must then step down the priority ladder, which tells a correct order apart from a swapped pair of causes. A separate pattern holds the transmit-empty pending flag set while a receive cause masks it. This separates clearing on any identification read from clearing only when transmit-empty is actually reported. Enable rewrites with bit1 already set, together with all causes present while every enable is off, show that the pending flag is edge-triggered and that the interrupt line is gated by the enables.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int unsigned CODE_W = 4;

  typedef logic [CODE_W-1:0] irq_code_t;

  localparam irq_code_t CODE_NONE  = 4'h1;
  localparam irq_code_t CODE_LINE  = 4'h6;
  localparam irq_code_t CODE_RXTO  = 4'hC;
  localparam irq_code_t CODE_THRE  = 4'h2;
  localparam irq_code_t CODE_MODEM = 4'h0;

  localparam int unsigned EN_RX    = 0;
  localparam int unsigned EN_THRE  = 1;
  localparam int unsigned EN_LINE  = 2;
  localparam int unsigned EN_MODEM = 3;

  localparam logic [2:0] OFS_DATA  = 3'd0;
  localparam logic [2:0] OFS_IEN   = 3'd1;
  localparam logic [2:0] OFS_IDENT = 3'd2;
  localparam logic [2:0] OFS_LSTAT = 3'd5;
  localparam logic [2:0] OFS_SCR   = 3'd7;

  typedef struct packed {
    logic ovr;
    logic rx_ne;
    logic thre;
    logic mdelta;
  } cause_t;

endpackage

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int unsigned EN_W = 4
) (
  input  logic [EN_W-1:0] en,
  input  cause_t          cause,
  output irq_code_t       code,
  output logic            active
);

  logic [3:0] hit;

  always_comb begin
    hit[0] = cause.ovr    & en[EN_LINE];
    hit[1] = cause.rx_ne  & en[EN_RX];
    hit[2] = cause.thre   & en[EN_THRE];
    hit[3] = cause.mdelta & en[EN_MODEM];
  end

  always_comb begin
    if (hit[0])      code = CODE_LINE;
    else if (hit[1]) code = CODE_RXTO;
    else if (hit[2]) code = CODE_THRE;
    else if (hit[3]) code = CODE_MODEM;
    else             code = CODE_NONE;
  end

  assign active = |hit;

endmodule

// File: rtl/uart_irq_state.sv
module uart_irq_state
  import uart_irq_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned EN_W     = 4,
  parameter int unsigned DIV_INIT = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_data,
  input  logic              wr_ien,
  input  logic              wr_fcr,
  input  logic              wr_scr,
  input  logic              wr_dlo,
  input  logic              wr_dhi,
  input  logic              rd_ident,
  input  logic              rd_lstat,
  input  logic              ovr_evt,
  input  irq_code_t         code_now,
  output logic [EN_W-1:0]   ien_q,
  output logic [EN_W-1:0]   ien_d,
  output logic              thre_q,
  output logic              thre_d,
  output logic              ovr_q,
  output logic              ovr_d,
  output logic              fifo_q,
  output logic [DATA_W-1:0] scr_q,
  output logic [DATA_W-1:0] div_lo_q,
  output logic [DATA_W-1:0] div_hi_q
);

  localparam logic [2*DATA_W-1:0] DIV_RST = (2*DATA_W)'(DIV_INIT);

  logic thre_rise;

  assign thre_rise = wr_ien & wdata[EN_THRE] & ~ien_q[EN_THRE];

  always_comb begin
    ien_d = wr_ien ? wdata[EN_W-1:0] : ien_q;

    thre_d = thre_q;
    if (rd_ident && code_now == CODE_THRE) thre_d = 1'b0;
    if (wr_data || thre_rise)              thre_d = 1'b1;

    ovr_d = ovr_q;
    if (rd_lstat) ovr_d = 1'b0;
    if (ovr_evt)  ovr_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q    <= '0;
      thre_q   <= 1'b0;
      ovr_q    <= 1'b0;
      fifo_q   <= 1'b0;
      scr_q    <= '0;
      div_lo_q <= DIV_RST[DATA_W-1:0];
      div_hi_q <= DIV_RST[2*DATA_W-1:DATA_W];
    end else begin
      ien_q  <= ien_d;
      thre_q <= thre_d;
      ovr_q  <= ovr_d;
      if (wr_fcr) fifo_q   <= wdata[0];
      if (wr_scr) scr_q    <= wdata;
      if (wr_dlo) div_lo_q <= wdata;
      if (wr_dhi) div_hi_q <= wdata;
    end
  end

endmodule

// File: rtl/uart_irq_rdmux.sv
module uart_irq_rdmux
  import uart_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned EN_W   = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              dlab,
  input  logic [DATA_W-1:0] rx_head,
  input  logic              rx_nonempty,
  input  logic [EN_W-1:0]   ien_q,
  input  logic              ovr_q,
  input  logic              fifo_q,
  input  irq_code_t         code_now,
  input  logic [DATA_W-1:0] scr_q,
  input  logic [DATA_W-1:0] div_lo_q,
  input  logic [DATA_W-1:0] div_hi_q,
  output logic [DATA_W-1:0] rd_val
);

  localparam int unsigned PAD_W = DATA_W - EN_W;

  always_comb begin
    rd_val = '0;
    case (addr)
      OFS_DATA:  rd_val = dlab ? div_lo_q : rx_head;
      OFS_IEN:   rd_val = dlab ? div_hi_q : {{PAD_W{1'b0}}, ien_q};
      OFS_IDENT: begin
        rd_val[CODE_W-1:0]       = code_now;
        rd_val[DATA_W-1]         = fifo_q;
        rd_val[DATA_W-2]         = fifo_q;
      end
      OFS_LSTAT: begin
        rd_val[0] = rx_nonempty;
        rd_val[1] = ovr_q;
        rd_val[5] = 1'b1;
        rd_val[6] = 1'b1;
      end
      OFS_SCR:   rd_val = scr_q;
      default:   rd_val = '0;
    endcase
  end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned REF_HZ = 1843200,
  parameter int unsigned BAUD   = 9600
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              dlab,
  input  logic              rx_nonempty,
  input  logic [DATA_W-1:0] rx_head,
  input  logic              ovr_evt,
  input  logic              msr_delta,
  output logic [DATA_W-1:0] rdata,
  output logic              rx_pop,
  output logic              irq
);

  localparam int unsigned EN_W     = 4;
  localparam int unsigned DIV_INIT = REF_HZ / BAUD / 16;

  logic at_data, at_ien, at_ident, at_lstat, at_scr;
  logic wr_data, wr_ien, wr_fcr, wr_scr, wr_dlo, wr_dhi;
  logic rd_ident, rd_lstat;

  logic [EN_W-1:0]   ien_q, ien_d;
  logic              thre_q, thre_d, ovr_q, ovr_d, fifo_q;
  logic [DATA_W-1:0] scr_q, div_lo_q, div_hi_q, rd_val;
  irq_code_t         code_now, code_nxt;
  logic              act_now, act_nxt;
  cause_t            cause_now, cause_nxt;

  assign at_data  = (addr == OFS_DATA);
  assign at_ien   = (addr == OFS_IEN);
  assign at_ident = (addr == OFS_IDENT);
  assign at_lstat = (addr == OFS_LSTAT);
  assign at_scr   = (addr == OFS_SCR);

  assign wr_data  = wr_en & ~dlab & at_data;
  assign wr_ien   = wr_en & ~dlab & at_ien;
  assign wr_dlo   = wr_en &  dlab & at_data;
  assign wr_dhi   = wr_en &  dlab & at_ien;
  assign wr_fcr   = wr_en & at_ident;
  assign wr_scr   = wr_en & at_scr;
  assign rd_ident = rd_en & at_ident;
  assign rd_lstat = rd_en & at_lstat;
  assign rx_pop   = rd_en & ~dlab & at_data;

  uart_irq_state #(
    .DATA_W  (DATA_W),
    .EN_W    (EN_W),
    .DIV_INIT(DIV_INIT)
  ) u_state (
    .clk     (clk),
    .rst     (rst),
    .wdata   (wdata),
    .wr_data (wr_data),
    .wr_ien  (wr_ien),
    .wr_fcr  (wr_fcr),
    .wr_scr  (wr_scr),
    .wr_dlo  (wr_dlo),
    .wr_dhi  (wr_dhi),
    .rd_ident(rd_ident),
    .rd_lstat(rd_lstat),
    .ovr_evt (ovr_evt),
    .code_now(code_now),
    .ien_q   (ien_q),
    .ien_d   (ien_d),
    .thre_q  (thre_q),
    .thre_d  (thre_d),
    .ovr_q   (ovr_q),
    .ovr_d   (ovr_d),
    .fifo_q  (fifo_q),
    .scr_q   (scr_q),
    .div_lo_q(div_lo_q),
    .div_hi_q(div_hi_q)
  );

  always_comb begin
    cause_now = '{ovr: ovr_q, rx_ne: rx_nonempty, thre: thre_q, mdelta: msr_delta};
    cause_nxt = '{ovr: ovr_d, rx_ne: rx_nonempty, thre: thre_d, mdelta: msr_delta};
  end

  uart_irq_prio #(.EN_W(EN_W)) u_prio_now (
    .en    (ien_q),
    .cause (cause_now),
    .code  (code_now),
    .active(act_now)
  );

  uart_irq_prio #(.EN_W(EN_W)) u_prio_nxt (
    .en    (ien_d),
    .cause (cause_nxt),
    .code  (code_nxt),
    .active(act_nxt)
  );

  uart_irq_rdmux #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .EN_W  (EN_W)
  ) u_rdmux (
    .addr       (addr),
    .dlab       (dlab),
    .rx_head    (rx_head),
    .rx_nonempty(rx_nonempty),
    .ien_q      (ien_q),
    .ovr_q      (ovr_q),
    .fifo_q     (fifo_q),
    .code_now   (code_now),
    .scr_q      (scr_q),
    .div_lo_q   (div_lo_q),
    .div_hi_q   (div_hi_q),
    .rd_val     (rd_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_val;
      irq <= act_nxt;
    end
  end

  logic unused_ok;
  assign unused_ok = act_now ^ (code_nxt == CODE_NONE);

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic              dlab,
  input logic [DATA_W-1:0] rdata,
  input logic              ovr_evt,
  input logic              ovr_q,
  input logic              thre_q,
  input logic              fifo_q,
  input logic [DATA_W-1:0] div_lo_q
);

  // R2
  ien_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 3'd1 && !dlab) |=> (rdata[7:4] == 4'h0));

  // R9
  lstat_fixed_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 3'd5) |=> (rdata[6:5] == 2'b11));

  // R9
  ovr_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 3'd5 && !ovr_evt) |=> !ovr_q);

  // R5
  thre_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 3'd2) ##1 (rdata[3:0] == 4'h2) |-> !thre_q);

  // R8
  fifo_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 3'd2) |=> (rdata[7:6] == {2{$past(fifo_q)}}));

  // R10
  div_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 3'd0 && dlab) |=> (rdata == $past(div_lo_q)));

endmodule

bind uart_irq_ident uart_irq_ident_chk #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .rd_en   (rd_en),
  .addr    (addr),
  .dlab    (dlab),
  .rdata   (rdata),
  .ovr_evt (ovr_evt),
  .ovr_q   (ovr_q),
  .thre_q  (thre_q),
  .fifo_q  (fifo_q),
  .div_lo_q(div_lo_q)
);

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rd_en = 1'b0, wr_en = 1'b0, dlab = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rx_head = '0;
  logic       rx_nonempty = 1'b0, ovr_evt = 1'b0, msr_delta = 1'b0;
  logic [7:0] rdata;
  logic       rx_pop, irq;

  int checks = 0;
  int fails  = 0;
  int pops   = 0;
  bit done   = 1'b0;
  logic rd_q = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  uart_irq_ident uut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .dlab(dlab), .rx_nonempty(rx_nonempty), .rx_head(rx_head),
    .ovr_evt(ovr_evt), .msr_delta(msr_delta), .rdata(rdata),
    .rx_pop(rx_pop), .irq(irq)
  );

  always @(posedge clk) begin
    rd_q <= rd_en;
    if (rx_pop) pops <= pops + 1;
  end

  // monitor: compares each read result one clock after its strobe
  always @(negedge clk) begin
    if (rd_q && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        fails++;
        $display("FAIL %s: rdata actual %02h expected %02h", t, rdata, e);
      end
    end
  end

  task automatic chk(input string t, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", t, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_ovr;
    @(negedge clk);
    ovr_evt = 1'b1;
    @(negedge clk);
    ovr_evt = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 irq after reset", {7'd0, irq}, 8'h00);
    rd(3'd2, 8'h01, "R1 ident reset");
    rd(3'd1, 8'h00, "R1 enable reset");
    dlab = 1'b1;
    rd(3'd0, 8'd12, "R1 R10 divisor low reset");
    rd(3'd1, 8'h00, "R1 R10 divisor high reset");
    wr(3'd0, 8'h34);
    wr(3'd1, 8'h01);
    rd(3'd0, 8'h34, "R10 divisor low write");
    rd(3'd1, 8'h01, "R10 divisor high write");
    chk("R13 no pop on divisor read", pops[7:0], 8'h00);
    chk("R10 enable untouched irq", {7'd0, irq}, 8'h00);
    dlab = 1'b0;
    rd(3'd1, 8'h00, "R10 enable untouched by divisor write");

    // rising transmit-empty enable
    wr(3'd1, 8'hFF);
    chk("R11 irq on pending transmit-empty", {7'd0, irq}, 8'h01);
    rd(3'd1, 8'h0F, "R2 upper nibble dropped");
    rd(3'd2, 8'h02, "R5 R6 ident reports transmit-empty");
    rd(3'd2, 8'h01, "R5 pending cleared by ident read");
    chk("R11 irq drops", {7'd0, irq}, 8'h00);
    wr(3'd1, 8'h0F);
    rd(3'd2, 8'h01, "R6 rewrite of set enable does not set pending");

    // masked pending survives an ident read
    wr(3'd0, 8'h55);
    rx_nonempty = 1'b1;
    settle();
    rd(3'd2, 8'h0C, "R4 receive code");
    rx_nonempty = 1'b0;
    rd(3'd2, 8'h02, "R7 pending kept while receive reported");
    rd(3'd2, 8'h01, "R5 pending cleared after report");

    // full ladder
    wr(3'd0, 8'hAA);
    msr_delta = 1'b1;
    rx_nonempty = 1'b1;
    pulse_ovr();
    rd(3'd2, 8'h06, "R3 overrun first");
    rd(3'd5, 8'h63, "R9 line status with overrun");
    rd(3'd2, 8'h0C, "R3 receive second");
    rd(3'd5, 8'h61, "R9 overrun cleared after read");
    rx_nonempty = 1'b0;
    rd(3'd2, 8'h02, "R3 transmit-empty third");
    rd(3'd2, 8'h00, "R3 modem last");
    chk("R11 irq with modem delta", {7'd0, irq}, 8'h01);
    msr_delta = 1'b0;
    settle();
    chk("R11 irq none", {7'd0, irq}, 8'h00);
    rd(3'd2, 8'h01, "R3 none pending");

    // all causes present, enables off
    wr(3'd1, 8'h00);
    rx_nonempty = 1'b1;
    msr_delta = 1'b1;
    pulse_ovr();
    wr(3'd0, 8'h11);
    settle();
    chk("R11 irq gated by enables", {7'd0, irq}, 8'h00);
    rd(3'd2, 8'h01, "R3 disabled causes not reported");
    rx_nonempty = 1'b0;
    msr_delta = 1'b0;
    rd(3'd5, 8'h62, "R9 overrun held without enable");
    rd(3'd5, 8'h60, "R9 overrun gone");

    // FIFO bits
    wr(3'd2, 8'h01);
    rd(3'd2, 8'hC1, "R8 fifo bits set");
    wr(3'd2, 8'h00);
    rd(3'd2, 8'h01, "R8 fifo bits clear");

    // scratch and ignored offsets
    wr(3'd7, 8'hA5);
    rd(3'd7, 8'hA5, "R12 scratch readback");
    wr(3'd5, 8'hFF);
    rd(3'd5, 8'h60, "R12 line status write ignored");
    wr(3'd6, 8'hFF);
    rd(3'd6, 8'h00, "R12 offset 6 reads zero");
    rd(3'd3, 8'h00, "R12 offset 3 reads zero");
    rd(3'd7, 8'hA5, "R12 scratch kept");

    // data read pops
    rx_head = 8'h3C;
    rx_nonempty = 1'b1;
    rd(3'd0, 8'h3C, "R13 data read returns head");
    chk("R13 one pop", pops[7:0], 8'h01);
    rx_nonempty = 1'b0;

    settle();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule